// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block multiplies and divides 32-bit integers one bit per clock and keeps its results in a private pair of 32-bit registers, HI and LO. A multiply leaves the 64-bit product split across the pair with the upper half in HI. A divide leaves the quotient in LO and the remainder in HI. Two accumulate operations add a fresh product onto whatever the pair already holds. When the caller only needs the low 32 bits of a product, it reads them through LO.

The caller pulses `start` for one cycle and presents an operation code and two operands with it. A long operation (multiply, accumulate or divide) keeps `busy` high for exactly the iteration count and then commits to HI/LO. Move-to operations write one register on the strobe edge. Move-from operations return a register value on `rd_data`, qualified by a one-cycle `rd_valid`. A move-from that arrives while the unit is busy is held and then served with the newly committed value.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low and both HI and LO read as zero.
- R2: Operation code 0 (signed multiply) writes the two's-complement 64-bit product of `opa` and `opb`, with bits 63:32 in HI and bits 31:0 in LO.
- R3: Operation code 1 (unsigned multiply) writes the unsigned 64-bit product into HI:LO in the same split.
- R4: Operation code 2 (signed accumulate) adds the signed 64-bit product to the HI:LO contents and writes the sum back to HI:LO, modulo 2^64.
- R5: Operation code 3 (unsigned accumulate) adds the unsigned 64-bit product to HI:LO, modulo 2^64.
- R6: Operation code 4 (signed divide) puts in LO the quotient truncated toward zero and in HI the remainder carrying the dividend's sign. The quotient of the most negative value by -1 wraps to the most negative value, with remainder 0.
- R7: Operation code 5 (unsigned divide) puts the unsigned quotient in LO and the unsigned remainder in HI.
- R8: A divide by zero, signed or unsigned, finishes in the normal cycle count and leaves LO all ones and HI equal to the dividend.
- R9: A long operation accepted on a clock edge drives `busy` high from that edge for exactly 32 cycles. HI/LO carry the result on the edge where `busy` falls.
- R10: Codes 8 and 9 write `opa` into HI and LO respectively on the strobe edge. Codes 6 and 7 issued while idle return HI and LO respectively on `rd_data`, with `rd_valid` high for the single cycle after the strobe edge.
- R11: A move-from issued while `busy` is high is held and delivered with the committed result, with `rd_valid` rising on the edge where `busy` falls.
- R12: A long-operation or move-to strobe while `busy` is high is ignored: the running operation is neither restarted nor lengthened, and HI/LO are not written by that strobe.
- R13: Operation codes 10 to 15 do nothing: `busy` and `rd_valid` stay low and HI/LO keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 4 | Operation code (see requirements) |
| opa | input | 32 | First operand: multiplicand, dividend or move-to value |
| opb | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | High while a long operation iterates |
| rd_valid | output | 1 | One-cycle qualifier for `rd_data` |
| rd_data | output | 32 | HI or LO value returned by a move-from |

## Verification
Let edge k be the one that samples a long-operation strobe. `busy` must then read high at the 32 falling edges that follow, and low at the falling edge after edge k+32. The bench counts those falling edges and checks the count is exactly 32. Results reach the outside only through move-from reads. Each read is strobed on one falling edge and its `rd_data` is checked at the next one, after the sampling edge has gone by. For a move-from held during a busy period, the bench counts falling edges from the original strobe and expects `rd_valid` at count 33, together with `busy` low.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [3:0] {
    OP_MUL   = 4'd0,
    OP_MULU  = 4'd1,
    OP_MACC  = 4'd2,
    OP_MACCU = 4'd3,
    OP_DIV   = 4'd4,
    OP_DIVU  = 4'd5,
    OP_MFHI  = 4'd6,
    OP_MFLO  = 4'd7,
    OP_MTHI  = 4'd8,
    OP_MTLO  = 4'd9
  } md_op_e;

  function automatic logic op_is_long(input logic [3:0] code);
    return code <= 4'd5;
  endfunction

  function automatic logic op_is_signed(input logic [3:0] code);
    return (code == 4'd0) || (code == 4'd2) || (code == 4'd4);
  endfunction

endpackage

// File: rtl/mul_iter.sv
module mul_iter #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod_nxt
);

  logic [2*W-1:0] acc_q, acc_d;
  logic [W-1:0]   mc_q, mc_d;
  logic [W:0]     upper_sum;

  // one shift-add step: conditionally add multiplicand to the upper half, then shift right
  always_comb begin
    upper_sum = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mc_q} : '0);
    prod_nxt  = {upper_sum, acc_q[W-1:1]};
  end

  always_comb begin
    acc_d = acc_q;
    mc_d  = mc_q;
    if (load) begin
      acc_d = {{W{1'b0}}, mplier};
      mc_d  = mcand;
    end else if (step) begin
      acc_d = prod_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mc_q  <= '0;
    end else begin
      acc_q <= acc_d;
      mc_q  <= mc_d;
    end
  end

endmodule

// File: rtl/div_iter.sv
module div_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] quo_nxt,
  output logic [W-1:0] rem_nxt
);

  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic [W:0]   shifted;
  logic [W:0]   trial;
  logic         fits;

  // one restoring step: bring in the next dividend bit, subtract if it fits
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = ~trial[W];
    rem_nxt = fits ? trial[W-1:0] : shifted[W-1:0];
    quo_nxt = {quo_q[W-2:0], fits};
  end

  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    if (load) begin
      rem_d = '0;
      quo_d = dvd;
      dvs_d = dvs;
    end else if (step) begin
      rem_d = rem_nxt;
      quo_d = quo_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
    end
  end

  // partial remainder never reaches a nonzero divisor (R6, R7)
  a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  // state
  logic           busy_q, busy_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [3:0]     kind_q, kind_d;
  logic           neg_q, neg_d;
  logic           negr_q, negr_d;
  logic           dvz_q, dvz_d;
  logic [W-1:0]   dvd_q, dvd_d;
  logic [W-1:0]   hi_q, hi_d, lo_q, lo_d;
  logic           pend_q, pend_d;
  logic           psel_q, psel_d;
  logic           rdv_q, rdv_d;
  logic [W-1:0]   rdd_q, rdd_d;

  // decode
  md_op_e         op_e;
  logic           accept, launch, finish, mf_now, mf_hi;
  logic           sgn, a_neg, b_neg;
  logic [W-1:0]   mag_a, mag_b;

  // datapath results
  logic [2*W-1:0] prod_raw, prod_fix, pair_sum;
  logic [W-1:0]   quo_raw, rem_raw, quo_fix, rem_fix;
  logic [W-1:0]   hi_res, lo_res;

  always_comb begin
    op_e   = md_op_e'(op);
    accept = start && !busy_q;
    launch = accept && op_is_long(op);
    finish = busy_q && (cnt_q == LAST);
    mf_now = start && ((op_e == OP_MFHI) || (op_e == OP_MFLO));
    mf_hi  = (op_e == OP_MFHI);
    sgn    = op_is_signed(op);
    a_neg  = sgn && opa[W-1];
    b_neg  = sgn && opb[W-1];
    mag_a  = a_neg ? (~opa + 1'b1) : opa;
    mag_b  = b_neg ? (~opb + 1'b1) : opb;
  end

  mul_iter #(.W(W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .step     (busy_q),
    .mcand    (mag_a),
    .mplier   (mag_b),
    .prod_nxt (prod_raw)
  );

  div_iter #(.W(W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .step    (busy_q),
    .dvd     (mag_a),
    .dvs     (mag_b),
    .quo_nxt (quo_raw),
    .rem_nxt (rem_raw)
  );

  // sign fix-up and commit value, valid on the final iteration edge
  always_comb begin
    prod_fix = neg_q  ? (~prod_raw + 1'b1) : prod_raw;
    quo_fix  = neg_q  ? (~quo_raw + 1'b1)  : quo_raw;
    rem_fix  = negr_q ? (~rem_raw + 1'b1)  : rem_raw;
    pair_sum = {hi_q, lo_q} + prod_fix;
    case (kind_q)
      4'd0, 4'd1: {hi_res, lo_res} = prod_fix;
      4'd2, 4'd3: {hi_res, lo_res} = pair_sum;
      4'd4, 4'd5: begin
        if (dvz_q) begin
          hi_res = dvd_q;
          lo_res = '1;
        end else begin
          hi_res = rem_fix;
          lo_res = quo_fix;
        end
      end
      default: begin
        hi_res = hi_q;
        lo_res = lo_q;
      end
    endcase
  end

  // control and operand capture
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    neg_d  = neg_q;
    negr_d = negr_q;
    dvz_d  = dvz_q;
    dvd_d  = dvd_q;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      kind_d = op;
      neg_d  = a_neg ^ b_neg;
      negr_d = a_neg;
      dvz_d  = (opb == '0);
      dvd_d  = opa;
    end else if (finish) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  // HI/LO register pair
  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (finish) begin
      hi_d = hi_res;
      lo_d = lo_res;
    end else if (accept && (op_e == OP_MTHI)) begin
      hi_d = opa;
    end else if (accept && (op_e == OP_MTLO)) begin
      lo_d = opa;
    end
  end

  // read port with one held request while busy
  always_comb begin
    rdv_d  = 1'b0;
    rdd_d  = rdd_q;
    pend_d = pend_q;
    psel_d = psel_q;
    if (!busy_q) begin
      if (mf_now) begin
        rdv_d = 1'b1;
        rdd_d = mf_hi ? hi_q : lo_q;
      end
    end else if (!finish) begin
      if (mf_now && !pend_q) begin
        pend_d = 1'b1;
        psel_d = mf_hi;
      end
    end else begin
      if (pend_q) begin
        rdv_d  = 1'b1;
        rdd_d  = psel_q ? hi_res : lo_res;
        pend_d = 1'b0;
      end else if (mf_now) begin
        rdv_d = 1'b1;
        rdd_d = mf_hi ? hi_res : lo_res;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= '0;
      neg_q  <= 1'b0;
      negr_q <= 1'b0;
      dvz_q  <= 1'b0;
      dvd_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      pend_q <= 1'b0;
      psel_q <= 1'b0;
      rdv_q  <= 1'b0;
      rdd_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      neg_q  <= neg_d;
      negr_q <= negr_d;
      dvz_q  <= dvz_d;
      dvd_q  <= dvd_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      pend_q <= pend_d;
      psel_q <= psel_d;
      rdv_q  <= rdv_d;
      rdd_q  <= rdd_d;
    end
  end

  assign busy     = busy_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  // R9: busy only rises after a strobe, and drops after the last iteration
  a_r9_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));
  a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> !busy_q);

  // R12: result pair untouched while iterating
  a_r12_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> ($stable(hi_q) && $stable(lo_q)));

  // R11: read data never returned during an iteration
  a_r11_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |-> !busy_q);

  // R8: divide by zero leaves LO all ones
  a_r8_dvz_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST && dvz_q && (kind_q == 4'd4 || kind_q == 4'd5))
      |=> (lo_q == '1));

endmodule

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic        busy, rd_valid;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  muldiv_hilo uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .opa      (opa),
    .opb      (opb),
    .busy     (busy),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always #10 clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // strobe one operation for a single sampling edge
  task automatic pulse(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = c; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0; op = 4'hF;
  endtask

  task automatic read_reg(input logic hi_sel, output logic [31:0] d, output logic v);
    @(negedge clk);
    start = 1'b1; op = hi_sel ? 4'd6 : 4'd7;
    @(negedge clk);
    v = rd_valid; d = rd_data;
    start = 1'b0; op = 4'hF;
  endtask

  task automatic check_pair(input string tag, input logic [31:0] eh, input logic [31:0] el);
    logic [31:0] d; logic v;
    read_reg(1'b1, d, v);
    check(v && d == eh, {tag, " HI"}, {31'b0, v, d}, {32'h1, eh});
    read_reg(1'b0, d, v);
    check(v && d == el, {tag, " LO"}, {31'b0, v, d}, {32'h1, el});
  endtask

  task automatic set_pair(input logic [31:0] h, input logic [31:0] l);
    pulse(4'd8, h, 32'h0);
    pulse(4'd9, l, 32'h0);
  endtask

  // run a long op and count falling edges with busy high
  task automatic run_long(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b, output int cyc);
    @(negedge clk);
    start = 1'b1; op = c; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0; op = 4'hF;
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check(!busy && !rd_valid, "R1 flags", {62'b0, busy, rd_valid}, 64'h0);
    check_pair("R1 reset", 32'h0, 32'h0);
  endtask

  task automatic t_moves;
    logic [31:0] d; logic v;
    pulse(4'd8, 32'hCAFE_0001, 32'h0);
    pulse(4'd9, 32'h0BAD_F00D, 32'h0);
    read_reg(1'b1, d, v);
    check(v && d == 32'hCAFE_0001, "R10 MTHI/MFHI", {31'b0, v, d}, {32'h1, 32'hCAFE_0001});
    @(negedge clk);
    check(!rd_valid, "R10 valid one cycle", {63'b0, rd_valid}, 64'h0);
    read_reg(1'b0, d, v);
    check(v && d == 32'h0BAD_F00D, "R10 MTLO/MFLO", {31'b0, v, d}, {32'h1, 32'h0BAD_F00D});
  endtask

  task automatic t_mul_signed;
    int cyc;
    run_long(4'd0, 32'hFFFF_FFF9, 32'd6, cyc);
    check(cyc == 32, "R9 mul busy length", 64'(cyc), 64'd32);
    check_pair("R2 -7*6", 32'hFFFF_FFFF, 32'hFFFF_FFD6);
    run_long(4'd0, 32'h8000_0000, 32'h8000_0000, cyc);
    check_pair("R2 min*min", 32'h4000_0000, 32'h0);
    run_long(4'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, cyc);
    check_pair("R2 max*-1", 32'hFFFF_FFFF, 32'h8000_0001);
  endtask

  task automatic t_mul_unsigned;
    int cyc;
    run_long(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, cyc);
    check_pair("R3 ones*ones", 32'hFFFF_FFFE, 32'h0000_0001);
    run_long(4'd1, 32'd3, 32'd5, cyc);
    check_pair("R3 3*5", 32'h0, 32'd15);
  endtask

  task automatic t_macc;
    int cyc;
    set_pair(32'h0, 32'd10);
    run_long(4'd2, 32'hFFFF_FFFE, 32'd3, cyc);
    check_pair("R4 10+(-6)", 32'h0, 32'd4);
    set_pair(32'h0, 32'd2);
    run_long(4'd2, 32'hFFFF_FFFE, 32'd3, cyc);
    check_pair("R4 2+(-6)", 32'hFFFF_FFFF, 32'hFFFF_FFFC);
    set_pair(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_long(4'd3, 32'd1, 32'd1, cyc);
    check_pair("R5 wrap", 32'h0, 32'h0);
    set_pair(32'h0, 32'd1);
    run_long(4'd3, 32'hFFFF_FFFF, 32'd2, cyc);
    check_pair("R5 unsigned acc", 32'h1, 32'hFFFF_FFFF);
  endtask

  task automatic t_div;
    int cyc;
    run_long(4'd4, 32'hFFFF_FFF9, 32'd2, cyc);
    check(cyc == 32, "R9 div busy length", 64'(cyc), 64'd32);
    check_pair("R6 -7/2", 32'hFFFF_FFFF, 32'hFFFF_FFFD);
    run_long(4'd4, 32'd7, 32'hFFFF_FFFE, cyc);
    check_pair("R6 7/-2", 32'h1, 32'hFFFF_FFFD);
    run_long(4'd4, 32'h8000_0000, 32'hFFFF_FFFF, cyc);
    check_pair("R6 min/-1", 32'h0, 32'h8000_0000);
    run_long(4'd5, 32'hFFFF_FFFF, 32'd10, cyc);
    check_pair("R7 unsigned", 32'd5, 32'h1999_9999);
  endtask

  task automatic t_dvz;
    int cyc;
    run_long(4'd4, 32'hFFFF_FFFB, 32'h0, cyc);
    check(cyc == 32, "R8 dvz busy length", 64'(cyc), 64'd32);
    check_pair("R8 signed dvz", 32'hFFFF_FFFB, 32'hFFFF_FFFF);
    run_long(4'd5, 32'd77, 32'h0, cyc);
    check_pair("R8 unsigned dvz", 32'd77, 32'hFFFF_FFFF);
  endtask

  task automatic t_pending;
    int n;
    logic got;
    logic [31:0] d;
    @(negedge clk);
    start = 1'b1; op = 4'd5; opa = 32'd100; opb = 32'd7;
    n = 0; got = 1'b0; d = '0;
    while (!got && n < 60) begin
      @(negedge clk);
      n++;
      start = 1'b0; op = 4'hF;
      if (n == 5) begin start = 1'b1; op = 4'd7; end
      if (rd_valid) begin got = 1'b1; d = rd_data; end
    end
    start = 1'b0; op = 4'hF;
    check(got && n == 33, "R11 held read timing", 64'(n), 64'd33);
    check(!busy, "R11 busy low at delivery", {63'b0, busy}, 64'h0);
    check(d == 32'd14, "R11 held read value", {32'b0, d}, 64'd14);
  endtask

  task automatic t_ignore;
    int n;
    @(negedge clk);
    start = 1'b1; op = 4'd1; opa = 32'd3; opb = 32'd4;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      start = 1'b0; op = 4'hF;
      if (n == 3) begin start = 1'b1; op = 4'd8; opa = 32'hDEAD_0000; end
      if (n == 6) begin start = 1'b1; op = 4'd5; opa = 32'd9; opb = 32'd3; end
    end while (busy && n < 80);
    start = 1'b0; op = 4'hF;
    check(n == 33, "R12 no restart", 64'(n), 64'd33);
    check_pair("R12 pair", 32'h0, 32'd12);
  endtask

  task automatic t_undef;
    set_pair(32'h1111_2222, 32'h3333_4444);
    @(negedge clk);
    start = 1'b1; op = 4'hC; opa = 32'h55; opb = 32'h2;
    @(negedge clk);
    start = 1'b0; op = 4'hF;
    check(!busy && !rd_valid, "R13 no activity", {62'b0, busy, rd_valid}, 64'h0);
    check_pair("R13 pair kept", 32'h1111_2222, 32'h3333_4444);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 4'hF; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_moves();
    t_mul_signed();
    t_mul_unsigned();
    t_macc();
    t_div();
    t_dvz();
    t_pending();
    t_ignore();
    t_undef();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule